// File: doc/BRIEF.md
# Fan PWM Generator with Period-Boundary Sync

This block produces one pulse-width modulated output for driving a fan. A two-stage prescaler, a linear divisor followed by a power-of-two shift, sets the length of one time quantum in clock cycles. A quantum counter walks from zero up to a programmed terminal value and then wraps, so that each period is a whole number of quanta. Within each period the waveform is active between a programmed rising quantum and a programmed falling quantum. When the two points are equal, the output is on for the whole period.

The configuration fields arrive as plain inputs, taken from a register bank outside the block. Two gates control the output. The run gate holds the counters at zero and forces the waveform inactive. The pin gate forces the pin to its idle level while the counters keep running. A polarity input inverts the pin at once. By default a new divider, period or compare setting is captured into a shadow copy only at the end of a period. A bypass input makes every change apply in the same cycle. Whenever the run gate is low, the shadow copy follows the inputs. As a result, settings written while the block is stopped are in force from the first cycle after restart.

Top module: `fan_pwm_gen`

## Requirements
- R1: One quantum lasts (div_lo + 1) << div_hi clock cycles. The quantum counter advances only at the end of a quantum.
- R2: One period lasts (period_q + 1) quanta. After the last quantum of a period, the quantum counter returns to 0.
- R3: With rise_pt < fall_pt, the waveform is active for quantum indices q with rise_pt <= q < fall_pt. With rise_pt > fall_pt, it is active for q >= rise_pt or q < fall_pt.
- R4: With rise_pt equal to fall_pt, the waveform is active in every cycle while clk_en is high.
- R5: While clk_en is low, both counters are held at 0 and the waveform is inactive in that same cycle, so the current period is cut short. On restart, the first quantum has its full length and starts at index 0.
- R6: While pin_en is low, pwm_o equals invert, which is the idle level, and the counters keep running.
- R7: Changing invert flips pwm_o and pwm_status in the same cycle, without waiting for a clock edge.
- R8: With sync_off low, changes to div_hi, div_lo, period_q, rise_pt and fall_pt take effect only from the start of the next period. While clk_en is low, they are taken directly, so they apply on restart.
- R9: With sync_off high, the live input settings drive the prescaler, the counter and the compare in the same cycle.
- R10: During reset, the counters and the shadow copy are 0. With clk_en low and invert low, both outputs are 0.
- R11: pwm_status is the waveform after inversion and before the pin gate. When pin_en is high, pwm_o equals pwm_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Run gate for counters and waveform |
| pin_en | input | 1 | Pin gate; low forces the idle level |
| invert | input | 1 | Output polarity; 1 makes the active level low |
| sync_off | input | 1 | 1 applies setting changes at once |
| div_hi | input | 4 | Prescaler shift amount |
| div_lo | input | 8 | Prescaler linear divisor minus one |
| period_q | input | 8 | Period length in quanta minus one |
| rise_pt | input | 8 | Quantum index where the waveform turns active |
| fall_pt | input | 8 | Quantum index where the waveform turns inactive |
| pwm_o | output | 1 | PWM pin |
| pwm_status | output | 1 | Waveform level after inversion, before the pin gate |

## Verification
Several events can fall in the same cycle. A compare point can be rewritten in the middle of a period while the shadow copy waits for that period's last quantum, and the run gate can drop in the same cycle that an inversion or a setting change arrives. The bench rewrites fall_pt part-way through a period, once with the bypass and once without. It counts active samples across the rest of that period and the whole of the next one, and so tells a deferred update from an immediate one. A behavioural model, updated on every edge, is compared with both outputs throughout the run. As a result, a gate change that coincides with a period wrap or with a shadow load is judged cycle by cycle.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

  localparam int DIVH_W = 4;
  localparam int DIVL_W = 8;
  localparam int PT_W   = 8;
  // widest quantum: (2^DIVL_W) << (2^DIVH_W - 1)
  localparam int QW     = DIVL_W + 1 + (1 << DIVH_W) - 1;

  typedef struct packed {
    logic [DIVH_W-1:0] div_hi;
    logic [DIVL_W-1:0] div_lo;
    logic [PT_W-1:0]   period;
    logic [PT_W-1:0]   rise;
    logic [PT_W-1:0]   fall;
  } cfg_t;

  // quantum length in clock cycles
  function automatic logic [QW-1:0] quantum_len(input logic [DIVH_W-1:0] h,
                                                input logic [DIVL_W-1:0] l);
    logic [QW-1:0] base;
    base = QW'(l) + QW'(1);
    return base << h;
  endfunction

  // active window test, wrapping when rise > fall, always on when equal
  function automatic logic in_window(input logic [PT_W-1:0] q,
                                     input logic [PT_W-1:0] r,
                                     input logic [PT_W-1:0] f);
    if (r == f)     return 1'b1;
    else if (r < f) return (q >= r) && (q < f);
    else            return (q >= r) || (q < f);
  endfunction

endpackage

// File: rtl/fanpwm_shadow.sv
module fanpwm_shadow
  import fanpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic sync_off,
  input  logic boundary,
  input  cfg_t cfg_raw,
  output cfg_t cfg_eff
);

  cfg_t shadow_q;
  logic load;

  // capture at period end, while stopped, or continuously when bypassed
  assign load = !clk_en || boundary || sync_off;

  always_ff @(posedge clk) begin
    if (!rst_n)    shadow_q <= '0;
    else if (load) shadow_q <= cfg_raw;
  end

  assign cfg_eff = sync_off ? cfg_raw : shadow_q;

endmodule

// File: rtl/fanpwm_prescaler.sv
module fanpwm_prescaler
  import fanpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [DIVH_W-1:0] div_hi,
  input  logic [DIVL_W-1:0] div_lo,
  output logic              tick
);

  logic [QW-1:0] pre_q;
  logic [QW-1:0] last_idx;

  assign last_idx = quantum_len(div_hi, div_lo) - QW'(1);
  // >= keeps the count bounded if the quantum shrinks mid-count
  assign tick     = clk_en && (pre_q >= last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (!clk_en) pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else              pre_q <= pre_q + QW'(1);
  end

endmodule

// File: rtl/fanpwm_period_cnt.sv
module fanpwm_period_cnt
  import fanpwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic            tick,
  input  logic [PT_W-1:0] period,
  output logic [PT_W-1:0] qcnt,
  output logic            boundary
);

  logic [PT_W-1:0] q_r;

  assign boundary = tick && (q_r >= period);
  assign qcnt     = q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)        q_r <= '0;
    else if (!clk_en)  q_r <= '0;
    else if (boundary) q_r <= '0;
    else if (tick)     q_r <= q_r + PT_W'(1);
  end

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fanpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              pin_en,
  input  logic              invert,
  input  logic              sync_off,
  input  logic [DIVH_W-1:0] div_hi,
  input  logic [DIVL_W-1:0] div_lo,
  input  logic [PT_W-1:0]   period_q,
  input  logic [PT_W-1:0]   rise_pt,
  input  logic [PT_W-1:0]   fall_pt,
  output logic              pwm_o,
  output logic              pwm_status
);

  cfg_t            cfg_raw;
  cfg_t            cfg_eff;
  logic            q_tick;
  logic            p_wrap;
  logic [PT_W-1:0] q_cnt;
  logic [PT_W-1:0] rise_eff;
  logic [PT_W-1:0] fall_eff;
  logic            wave_act;

  assign cfg_raw = '{div_hi: div_hi, div_lo: div_lo, period: period_q,
                     rise: rise_pt, fall: fall_pt};

  fanpwm_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .sync_off (sync_off),
    .boundary (p_wrap),
    .cfg_raw  (cfg_raw),
    .cfg_eff  (cfg_eff)
  );

  fanpwm_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .div_hi (cfg_eff.div_hi),
    .div_lo (cfg_eff.div_lo),
    .tick   (q_tick)
  );

  fanpwm_period_cnt u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .tick     (q_tick),
    .period   (cfg_eff.period),
    .qcnt     (q_cnt),
    .boundary (p_wrap)
  );

  assign rise_eff = cfg_eff.rise;
  assign fall_eff = cfg_eff.fall;

  // run gate acts combinationally so a stop cuts the period at once
  assign wave_act   = clk_en && in_window(q_cnt, rise_eff, fall_eff);
  assign pwm_status = wave_act ^ invert;
  assign pwm_o      = pin_en ? pwm_status : invert;

endmodule

// File: rtl/fanpwm_checker.sv
module fanpwm_checker
  import fanpwm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            clk_en,
  input logic            pin_en,
  input logic            invert,
  input logic            tick,
  input logic            boundary,
  input logic [PT_W-1:0] qcnt,
  input logic [PT_W-1:0] rise_eff,
  input logic [PT_W-1:0] fall_eff,
  input logic            pwm_o,
  input logic            pwm_status
);

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !tick) |=> $stable(qcnt));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (qcnt == '0));

  p_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && rise_eff == fall_eff) |-> (pwm_status != invert));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (qcnt == '0));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (pwm_status == invert));

  p_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> (pwm_o == invert));

  p_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pin_en |-> (pwm_o == pwm_status));

endmodule

bind fan_pwm_gen fanpwm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_en     (clk_en),
  .pin_en     (pin_en),
  .invert     (invert),
  .tick       (q_tick),
  .boundary   (p_wrap),
  .qcnt       (q_cnt),
  .rise_eff   (rise_eff),
  .fall_eff   (fall_eff),
  .pwm_o      (pwm_o),
  .pwm_status (pwm_status)
);

// File: tb/tb_fan_pwm_gen.sv
`timescale 1ns/1ps
module tb_fan_pwm_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0, pin_en = 1'b1, invert = 1'b0, sync_off = 1'b0;
  logic [3:0] div_hi = '0;
  logic [7:0] div_lo = '0, period_q = '0, rise_pt = '0, fall_pt = '0;
  logic       pwm_o, pwm_status;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;
  string tag = "R10";

  always #4 clk = ~clk;

  fan_pwm_gen dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pin_en(pin_en),
    .invert(invert), .sync_off(sync_off), .div_hi(div_hi), .div_lo(div_lo),
    .period_q(period_q), .rise_pt(rise_pt), .fall_pt(fall_pt),
    .pwm_o(pwm_o), .pwm_status(pwm_status)
  );

  // behavioural reference: integer state, updated on each rising edge
  int m_pre, m_q, s_dh, s_dl, s_per, s_r, s_f;

  function automatic bit m_active(int q, int r, int f);
    if (r == f) return 1;
    if (r < f)  return (q >= r && q < f);
    return (q >= r || q < f);
  endfunction

  always @(posedge clk) begin
    int dh, dl, per, qlen;
    bit tk, bnd;
    if (!rst_n) begin
      m_pre = 0; m_q = 0; s_dh = 0; s_dl = 0; s_per = 0; s_r = 0; s_f = 0;
    end else begin
      dh  = sync_off ? int'(div_hi)   : s_dh;
      dl  = sync_off ? int'(div_lo)   : s_dl;
      per = sync_off ? int'(period_q) : s_per;
      qlen = (dl + 1) * (1 << dh);
      tk  = clk_en && (m_pre >= qlen - 1);
      bnd = tk && (m_q >= per);
      if (!clk_en)  begin m_pre = 0; m_q = 0; end
      else if (tk)  begin m_pre = 0; m_q = bnd ? 0 : m_q + 1; end
      else          m_pre = m_pre + 1;
      if (!clk_en || bnd || sync_off) begin
        s_dh = div_hi; s_dl = div_lo; s_per = period_q; s_r = rise_pt; s_f = fall_pt;
      end
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      bit e_st;
      int r, f;
      #2;
      r = sync_off ? int'(rise_pt) : s_r;
      f = sync_off ? int'(fall_pt) : s_f;
      e_st = (clk_en && m_active(m_q, r, f)) ^ invert;
      check(tag, pwm_status, e_st, "model status");
      check(tag, pwm_o, pin_en ? e_st : invert, "model pin");
    end
  end

  task automatic set_cfg(int dh, int dl, int per, int r, int f);
    div_hi = dh[3:0]; div_lo = dl[7:0]; period_q = per[7:0];
    rise_pt = r[7:0]; fall_pt = f[7:0];
  endtask

  // stop one cycle, then restart; returns at the restart negedge
  task automatic restart();
    @(negedge clk); clk_en = 1'b0;
    @(negedge clk); clk_en = 1'b1;
  endtask

  // count high status samples over n cycles starting at the current negedge
  task automatic count_high(int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      #3;
      if (pwm_status) hi++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1 - 1);
    $finish;
  end

  initial begin
    int hi;
    logic s0;
    repeat (3) @(negedge clk);
    #3;
    check("R10", pwm_o, 1'b0, "reset pin");
    check("R10", pwm_status, 1'b0, "reset status");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); cmp_on = 1;

    // R1 R2 R3: Q = 3<<1 = 6, period 5 quanta = 30 cycles, active q 0..1
    tag = "R3"; sync_off = 1'b1; set_cfg(1, 2, 4, 0, 2);
    restart();
    hi = 0;
    for (int k = 0; k < 60; k++) begin
      if (k > 0) @(negedge clk);
      #3;
      if (pwm_status) hi++;
      if (k == 11) check("R1", pwm_status, 1'b1, "last active cycle");
      if (k == 12) check("R1", pwm_status, 1'b0, "first idle cycle");
      if (k == 29) check("R2", pwm_status, 1'b0, "end of period");
      if (k == 30) check("R2", pwm_status, 1'b1, "next period start");
    end
    check_int("R3", hi, 24, "active cycles over two periods");

    // R3 wrapped window: rise 3 fall 1 -> quanta 3,4,0 active
    tag = "R3"; set_cfg(1, 2, 4, 3, 1);
    restart(); count_high(60, hi);
    check_int("R3", hi, 36, "wrapped window active cycles");

    // R4 rise == fall -> always on
    tag = "R4"; set_cfg(0, 0, 7, 5, 5);
    restart(); count_high(40, hi);
    check_int("R4", hi, 40, "full duty active cycles");

    // R6 R11: pin gated with inversion, status keeps running
    tag = "R6"; set_cfg(1, 2, 4, 0, 2);
    restart();
    @(negedge clk); invert = 1'b1; pin_en = 1'b0;
    hi = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #3;
      if (pwm_o !== 1'b1) hi = hi + 100;
      if (pwm_status) hi++;
    end
    check_int("R6", hi, 18, "pin idle high, inverted status highs");
    @(negedge clk); pin_en = 1'b1; #3;
    check("R11", pwm_o, pwm_status, "pin follows status");

    // R7: inversion acts without a clock edge
    tag = "R7";
    @(negedge clk); #3; s0 = pwm_o;
    invert = ~invert; #1;
    check("R7", pwm_o, ~s0, "immediate inversion");
    @(negedge clk); invert = 1'b0;

    // R5: stop mid-period cuts the waveform at once
    tag = "R5"; restart();
    repeat (3) @(negedge clk);
    #3; check("R5", pwm_status, 1'b1, "active before stop");
    clk_en = 1'b0; #1;
    check("R5", pwm_status, 1'b0, "inactive in stop cycle");
    // R5 R8: settings written while stopped apply on restart (sync on)
    sync_off = 1'b0; set_cfg(0, 1, 3, 0, 1);
    repeat (2) @(negedge clk);
    clk_en = 1'b1; count_high(16, hi);
    check_int("R5", hi, 4, "restart with new settings");

    // R8: deferred change; Q=2, 8-cycle period, fall 1 -> 3 at index 3
    tag = "R8"; restart();
    repeat (3) @(negedge clk);
    fall_pt = 8'd3; count_high(13, hi);
    check_int("R8", hi, 6, "fall change held to next period");

    // R9: same scenario with bypass applies at once
    tag = "R9"; set_cfg(0, 1, 3, 0, 1);
    @(negedge clk); clk_en = 1'b0; sync_off = 1'b1;
    @(negedge clk); clk_en = 1'b1;
    repeat (3) @(negedge clk);
    fall_pt = 8'd3; count_high(13, hi);
    check_int("R9", hi, 9, "fall change immediate");

    // R1: larger shift, Q = 1<<3 = 8, period 2 quanta, active 1 quantum
    tag = "R1"; set_cfg(3, 0, 1, 0, 1);
    restart(); count_high(32, hi);
    check_int("R1", hi, 16, "shifted quantum active cycles");

    @(negedge clk); cmp_on = 0;
    #3;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule